// File: doc/BRIEF.md
# Interleaved Four-Bank Row Sequencer

This block produces, for a single access channel, the ordered series of (bank, row) targets that spreads row activations over the four banks of an SDRAM. Every access step occupies two banks that sit two positions apart. The even row of the current row pair goes to the first bank of the step, and the odd row that follows it goes to the partner bank, (first + 2) mod 4.

The first bank of a step moves through 0, 1, 2 and 3 on successive steps. After the fourth step the row pair moves up by two. The order is fixed and cannot be switched off. A start pulse loads a starting row and a sequence length counted in two-bank steps. Each step then leaves the block as two beats on a valid/ready handshake.

A done flag marks the final beat. After that beat is taken, the block goes back to idle and waits for the next start.

Top module: `bank_row_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the cycle after it, `valid` and `done` are 0.
- R2: A `start` pulse seen while idle with a nonzero `blockSteps` raises `valid` on the next cycle. The first beat then shows bank 0 and `secondHalf` = 0.
- R3: Within a step, the first beat (`secondHalf` = 0) carries an even row. The second beat (`secondHalf` = 1) carries bank (first bank + 2) mod 4 and that row plus one.
- R4: The first banks of successive steps follow 0, 1, 2, 3 and then repeat. Each time the order returns to bank 0, the row pair advances by two.
- R5: A beat is accepted only at a clock edge where `valid` and `ready` are both 1. While `ready` is 0, `bank`, `row` and `secondHalf` hold their values.
- R6: A run with length N yields exactly 2·N beats. `done` is 1 during the final beat only, and `valid` is 0 on the cycle after that beat is accepted.
- R7: If bit 0 of `startRow` is 1, it is treated as 0.
- R8: When the row pair passes the largest even row, it wraps to row 0 with no other effect.
- R9: A `start` pulse while a run is active has no effect on the rest of that run.
- R10: A `start` pulse with `blockSteps` = 0 leaves the block idle.
- R11: Reset in the middle of a run ends it. A later start then begins a fresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, used only while idle |
| startRow | input | ROW_W | First row of the run (LSB forced to 0) |
| blockSteps | input | STEP_W | Run length in two-bank steps |
| ready | input | 1 | Consumer accepts the current beat |
| valid | output | 1 | A beat is presented |
| bank | output | 2 | Bank of the current beat |
| row | output | ROW_W | Row of the current beat |
| secondHalf | output | 1 | 1 on the partner-bank beat of a step |
| done | output | 1 | 1 during the final beat of a run |

## Verification
The output register loads on the edge that samples `start`, so the first beat is due one cycle after the pulse. Every later beat is due one cycle after the edge that accepts the previous one, and `valid` drops one cycle after the final acceptance. The bench changes inputs and samples outputs on the falling edge. It expects a new beat on every falling edge while `ready` is held high, and an unchanged beat on every falling edge while `ready` is held low. Expected banks and rows come from the step index alone: first bank = index mod 4, and row = even start row + 2·(index / 4), taken modulo the row range.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int PAIR_DIST = NUM_BANKS / 2;

  typedef struct packed {
    logic load;        // capture start row, reset rotation
    logic stepAdv;     // a full step finished, move to next step
    logic secondHalf;  // current beat is the partner-bank beat
  } seqStrobes_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [STEP_W-1:0] blockSteps,
  input  logic              ready,
  output logic              active,
  output logic              lastBeat,
  output seqStrobes_t       strobes
);
  logic              half;
  logic [STEP_W-1:0] stepsLeft;
  logic              accept;
  logic              lastStep;

  assign accept   = active && ready;
  assign lastStep = (stepsLeft == STEP_W'(1));
  assign lastBeat = active && half && lastStep;

  always_comb begin
    strobes            = '0;
    strobes.load       = !active && start && (blockSteps != '0);
    strobes.stepAdv    = accept && half && !lastStep;
    strobes.secondHalf = half;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      half      <= 1'b0;
      stepsLeft <= '0;
    end else if (strobes.load) begin
      active    <= 1'b1;
      half      <= 1'b0;
      stepsLeft <= blockSteps;
    end else if (accept) begin
      if (!half) begin
        half <= 1'b1;
      end else begin
        half <= 1'b0;
        if (lastStep) begin
          active    <= 1'b0;
          stepsLeft <= '0;
        end else begin
          stepsLeft <= stepsLeft - STEP_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int ROW_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROW_W-2:0]  pairStart,
  input  seqStrobes_t       strobes,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  logic [BANK_W-1:0] firstBank;
  logic [ROW_W-2:0]  pairIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      firstBank <= '0;
      pairIdx   <= '0;
    end else if (strobes.load) begin
      firstBank <= '0;
      pairIdx   <= pairStart;
    end else if (strobes.stepAdv) begin
      firstBank <= firstBank + BANK_W'(1);
      if (firstBank == LAST_BANK) begin
        pairIdx <= pairIdx + (ROW_W-1)'(1);  // wraps at the top
      end
    end
  end

  assign bank = strobes.secondHalf ? BANK_W'(firstBank + BANK_W'(PAIR_DIST)) : firstBank;
  assign row  = {pairIdx, strobes.secondHalf};
endmodule

// File: rtl/bank_row_seq.sv
module bank_row_seq
  import seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ROW_W-1:0]  startRow,
  input  logic [STEP_W-1:0] blockSteps,
  input  logic              ready,
  output logic              valid,
  output logic [1:0]        bank,
  output logic [ROW_W-1:0]  row,
  output logic              secondHalf,
  output logic              done
);
  seqStrobes_t strobes;
  logic        active;
  logic        lastBeat;

  seq_ctrl #(.STEP_W(STEP_W)) ctrl (
    .clk(clk), .rst(rst), .start(start), .blockSteps(blockSteps),
    .ready(ready), .active(active), .lastBeat(lastBeat), .strobes(strobes)
  );

  seq_datapath #(.ROW_W(ROW_W)) dp (
    .clk(clk), .rst(rst), .pairStart(startRow[ROW_W-1:1]),
    .strobes(strobes), .bank(bank), .row(row)
  );

  assign valid      = active;
  assign secondHalf = strobes.secondHalf;
  assign done       = lastBeat;
endmodule

// File: rtl/bank_row_seq_checker.sv
module bank_row_seq_checker #(
  parameter int ROW_W  = 13,
  parameter int STEP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ROW_W-1:0]  startRow,
  input logic [STEP_W-1:0] blockSteps,
  input logic              ready,
  input logic              valid,
  input logic [1:0]        bank,
  input logic [ROW_W-1:0]  row,
  input logic              secondHalf,
  input logic              done
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !valid && !done); // R1

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    !valid && start && blockSteps != '0 |=>
      valid && bank == 2'd0 && !secondHalf && row == {$past(startRow[ROW_W-1:1]), 1'b0}); // R2

  AST_PARTNER_BEAT: assert property (@(posedge clk) disable iff (rst)
    valid && ready && !secondHalf |=>
      valid && secondHalf && bank == 2'($past(bank) + 2'd2) && row == ($past(row) | ROW_W'(1))); // R3

  AST_EVEN_FIRST: assert property (@(posedge clk) disable iff (rst)
    valid && !secondHalf |-> !row[0]); // R7

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid && $stable(bank) && $stable(row) && $stable(secondHalf)); // R5

  AST_DONE_FINAL: assert property (@(posedge clk) disable iff (rst)
    done |-> valid && secondHalf); // R6

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
    done && ready |=> !valid); // R6

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    !valid && start && blockSteps == '0 |=> !valid); // R10
endmodule

bind bank_row_seq bank_row_seq_checker #(.ROW_W(ROW_W), .STEP_W(STEP_W)) chk (
  .clk(clk), .rst(rst), .start(start), .startRow(startRow), .blockSteps(blockSteps),
  .ready(ready), .valid(valid), .bank(bank), .row(row), .secondHalf(secondHalf), .done(done)
);

// File: tb/bank_row_seq_test.sv
module bank_row_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 13;
  localparam int STEP_W = 8;
  localparam int ROW_MOD = 1 << ROW_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              start;
  logic [ROW_W-1:0]  startRow;
  logic [STEP_W-1:0] blockSteps;
  logic              ready;
  logic              valid;
  logic [1:0]        bank;
  logic [ROW_W-1:0]  row;
  logic              secondHalf;
  logic              done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bank_row_seq #(.ROW_W(ROW_W), .STEP_W(STEP_W)) uut (
    .clk(clk), .rst(rst), .start(start), .startRow(startRow), .blockSteps(blockSteps),
    .ready(ready), .valid(valid), .bank(bank), .row(row), .secondHalf(secondHalf), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic ok, input string what,
                       input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Sampled at a falling edge; with ready high the next rising edge takes the beat.
  task automatic expectBeat(input string req, input int b, input int r, input logic h,
                            input logic d);
    check(req, valid == 1'b1, "valid", int'(valid), 1);
    check(req, bank == 2'(b), "bank", int'(bank), b);
    check(req, row == ROW_W'(r), "row", int'(row), r);
    check(req, secondHalf == h, "secondHalf", int'(secondHalf), int'(h));
    check(req, done == d, "done", int'(done), int'(d));
    @(negedge clk);
  endtask

  task automatic pulseStart(input int r, input int n);
    start = 1'b1; startRow = ROW_W'(r); blockSteps = STEP_W'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Consume beats of steps [from, to) of a run starting at evenRow with n steps.
  task automatic expectSteps(input string req, input int evenRow, input int n,
                             input int from, input int to);
    for (int k = from; k < to; k++) begin
      int fb = k % 4;
      int r  = (evenRow + 2 * (k / 4)) % ROW_MOD;
      expectBeat(req, fb, r, 1'b0, 1'b0);
      expectBeat(req, (fb + 2) % 4, r + 1, 1'b1, k == n - 1);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; start = 1'b0; ready = 1'b1; startRow = '0; blockSteps = '0;
    repeat (3) @(negedge clk);
    check("R1", !valid && !done, "valid/done in reset", int'(valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", !valid && !done, "valid/done after reset", int'(valid), 0);
  endtask

  task automatic t_basic;
    pulseStart(4, 5);
    expectSteps("R2 R3 R4 R6", 4, 5, 0, 5);
    check("R6", !valid, "valid after last beat", int'(valid), 0);
  endtask

  task automatic t_stall;
    ready = 1'b0;
    pulseStart(10, 1);
    repeat (3) begin
      check("R5", valid && bank == 2'd0 && row == ROW_W'(10) && !secondHalf,
            "held beat row", int'(row), 10);
      @(negedge clk);
    end
    ready = 1'b1;
    expectBeat("R5", 0, 10, 1'b0, 1'b0);
    ready = 1'b0;
    @(negedge clk);
    check("R5", valid && secondHalf && bank == 2'd2, "held second beat bank", int'(bank), 2);
    ready = 1'b1;
    expectBeat("R5", 2, 11, 1'b1, 1'b1);
    check("R6", !valid, "valid after single step", int'(valid), 0);
  endtask

  task automatic t_odd;
    pulseStart(7, 1);
    expectSteps("R7", 6, 1, 0, 1);
  endtask

  task automatic t_wrap;
    pulseStart(ROW_MOD - 2, 5);
    expectSteps("R8", ROW_MOD - 2, 5, 0, 5);
    check("R8", !valid, "valid after wrap run", int'(valid), 0);
  endtask

  task automatic t_restart;
    pulseStart(0, 2);
    expectBeat("R9", 0, 0, 1'b0, 1'b0);
    start = 1'b1; startRow = ROW_W'(100); blockSteps = STEP_W'(9);
    expectBeat("R9", 2, 1, 1'b1, 1'b0);
    start = 1'b0;
    expectSteps("R9", 0, 2, 1, 2);
    check("R9", !valid, "run length kept", int'(valid), 0);
  endtask

  task automatic t_zero;
    pulseStart(20, 0);
    check("R10", !valid, "valid after zero-length start", int'(valid), 0);
    @(negedge clk);
    check("R10", !valid && !done, "still idle", int'(valid), 0);
  endtask

  task automatic t_midreset;
    pulseStart(40, 3);
    expectSteps("R11", 40, 3, 0, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11", !valid && !done, "valid after mid reset", int'(valid), 0);
    @(negedge clk);
    check("R11", !valid, "stays idle", int'(valid), 0);
    pulseStart(2, 1);
    expectSteps("R11", 2, 1, 0, 1);
    check("R11", !valid, "fresh run ended", int'(valid), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_stall();
    t_odd();
    t_wrap();
    t_restart();
    t_zero();
    t_midreset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule